// File: doc/BRIEF.md
# DDR Read-Burst Command Sequencer

This block sits on the controller side of a double-data-rate SDRAM and turns read requests into a command stream, one command per clock. Each request names a bank, a starting column, how many data pairs the caller wants, an auto-precharge flag and what should come after the read: another read, a write, a precharge, or nothing. The block issues the READ, fills the following cycles with NOP, and places a BURST TERMINATE, a PRECHARGE or a chained READ on the cycle whose distance from the READ equals the number of pairs wanted. Because the device moves two data elements per clock, a burst of length BL occupies BL/2 clocks of data, and a truncating command placed x cycles after the READ leaves exactly x pairs on the bus.

Alongside the commands the block drives a read-data window for the capture path. The window is delayed from the READ by the integer part of the CAS latency, and a separate flag marks the half-cycle latency setting, where capture starts on the falling clock edge. A write-permit output stays low until the last read pair has left the bus and a turnaround gap has passed. After a PRECHARGE, new requests to that bank are refused until a programmable precharge period has counted down. Requests to other banks are still accepted.

Top module: `ddr_rdseq`

## Requirements
- R1: After reset, cmd_code is NOP (0), rd_win and rd_win_fall are low, wr_ok is high and req_ready is high.
- R2: A request accepted (req_valid and req_ready high at a rising edge) puts READ (cmd_code 1) on cmd_code in the next cycle. In that cycle, cmd_bank, cmd_col and cmd_ap carry the request's bank, column and auto-precharge flag.
- R3: The pairs per burst are 1, 2 and 4 for cfg_bl codes 0, 1 and 2 (code 3 acts as 2). A req_pairs of 0, or one above the pairs per burst, is treated as a full burst.
- R4: With x pairs wanted, where x is below the pairs per burst, and a follow-up of none (0) or write (2), BURST TERMINATE (cmd_code 2) appears exactly x cycles after the READ. A full burst issues no terminate. Every other cycle of the burst carries NOP.
- R5: With follow-up precharge (3) and no auto-precharge, PRECHARGE (cmd_code 3) to the read's bank appears x cycles after the READ, in place of any terminate.
- R6: With auto-precharge set, req_pairs is ignored and the burst runs full length. No PRECHARGE or BURST TERMINATE is issued for it.
- R7: With follow-up read (1), req_ready is high in cycle x-1 after the READ and low in the cycles before it. A request accepted then puts its READ exactly x cycles after the first, so the data window has no gap. If no request arrives, the R4 rule applies at cycle x.
- R8: rd_win is high in cycles 2 through x+1 after the READ. rd_win_fall equals rd_win while cfg_cl_half is 1 and is low otherwise.
- R9: wr_ok is low from the READ cycle onward. With cfg_cl_half 0 it rises x+3 cycles after the READ; with cfg_cl_half 1 it rises x+4 cycles after the READ.
- R10: A PRECHARGE to bank b in cycle p holds req_ready low for requests naming b during cycles p through p+cfg_trp-1. Requests naming other banks are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_bl | input | 2 | Burst length code: 0 for 2, 1 for 4, 2 for 8 |
| cfg_cl_half | input | 1 | 1 selects a read latency of 2.5 clocks, 0 selects 2 |
| cfg_trp | input | TRP_W | Precharge period in clocks |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_bank | input | BANK_W | Request bank |
| req_col | input | COL_W | Request start column |
| req_pairs | input | PAIR_W | Data pairs wanted (0 means full burst) |
| req_follow | input | 2 | Follow-up: 0 none, 1 read, 2 write, 3 precharge |
| req_ap | input | 1 | Read with auto-precharge |
| cmd_code | output | 2 | Command: 0 NOP, 1 READ, 2 BURST TERMINATE, 3 PRECHARGE |
| cmd_bank | output | BANK_W | Bank for READ or PRECHARGE |
| cmd_col | output | COL_W | Column for READ |
| cmd_ap | output | 1 | Auto-precharge flag for READ |
| rd_win | output | 1 | Read data window, aligned to the rising edge |
| rd_win_fall | output | 1 | Read data window, starting on the falling edge |
| wr_ok | output | 1 | A write may be issued this cycle |

## Verification
Most wrong internal states show up on cmd_code first. A stale pair count or a miscounted burst index moves the terminate or precharge off cycle x, or puts a stray terminate after a full burst, and this appears within the burst itself, at most four cycles after the READ. A delay pipeline of the wrong depth, or a bad gap counter, shifts rd_win or wr_ok, and the per-cycle traces catch this two to five cycles later. A bank timer that is loaded at the wrong time or never clears shows up as a wrong req_ready in the cycles right after the PRECHARGE.

// File: rtl/ddr_rdseq_pkg.sv
// Shared encodings for the read-burst sequencer.
// Assumes: command and follow-up codes are fixed as listed; neighbours decode them.
package ddr_rdseq_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_READ = 2'd1,
        CMD_BST  = 2'd2,
        CMD_PRE  = 2'd3
    } rdcmd_e;

    typedef enum logic [1:0] {
        FOL_NONE  = 2'd0,
        FOL_READ  = 2'd1,
        FOL_WRITE = 2'd2,
        FOL_PRE   = 2'd3
    } follow_e;

endpackage

// File: rtl/rdseq_ctrl.sv
// Burst controller: accepts requests, issues READ and the end-of-burst command.
// Assumes: cfg_bl is static while a burst is running; the bank guard supplies the
// blocked flag for the bank currently presented on req_bank.
module rdseq_ctrl
    import ddr_rdseq_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int COL_W  = 10,
    parameter int PAIR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_bl,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [COL_W-1:0]  req_col,
    input  logic [PAIR_W-1:0] req_pairs,
    input  logic [1:0]        req_follow,
    input  logic              req_ap,
    input  logic              bank_blocked,
    output logic              req_ready,
    output logic [1:0]        cmd_code,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [COL_W-1:0]  cmd_col,
    output logic              cmd_ap,
    output logic              busy,
    output logic              pre_load,
    output logic [BANK_W-1:0] pre_bank
);

    typedef enum logic {ST_IDLE, ST_BURST} st_e;

    st_e               state;
    logic [PAIR_W-1:0] cnt;
    logic [PAIR_W-1:0] x_r;
    follow_e           follow_r;
    logic              ap_r;
    logic [BANK_W-1:0] bank_r;
    rdcmd_e            cmd_r;

    logic [PAIR_W-1:0] half_pairs;
    logic [PAIR_W-1:0] x_eff;
    logic              last;
    logic              accept;
    rdcmd_e            end_cmd;

    // Pairs per burst from the burst length code.
    always_comb begin
        case (cfg_bl)
            2'd0:    half_pairs = PAIR_W'(1);
            2'd1:    half_pairs = PAIR_W'(2);
            default: half_pairs = PAIR_W'(4);
        endcase
    end

    // Effective pair count: clamp, and force a full burst under auto-precharge.
    always_comb begin
        if (req_ap || req_pairs == '0 || req_pairs > half_pairs)
            x_eff = half_pairs;
        else
            x_eff = req_pairs;
    end

    // Cycle x-1 of the burst is where the end command is decided.
    assign last = (state == ST_BURST) && (cnt == x_r - PAIR_W'(1));

    // Ready when idle, or at the chaining point of a follow-up read.
    assign req_ready = !bank_blocked &&
                       ((state == ST_IDLE) || (last && follow_r == FOL_READ));
    assign accept    = req_valid && req_ready;

    // Command placed x cycles after the READ when nothing is chained.
    always_comb begin
        if (follow_r == FOL_PRE && !ap_r)
            end_cmd = CMD_PRE;
        else if (x_r < half_pairs)
            end_cmd = CMD_BST;
        else
            end_cmd = CMD_NOP;
    end

    assign pre_load = last && !accept && (follow_r == FOL_PRE) && !ap_r;
    assign pre_bank = bank_r;
    assign busy     = (state == ST_BURST);
    assign cmd_code = cmd_r;

    // Sequencer state and command register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            x_r      <= PAIR_W'(1);
            follow_r <= FOL_NONE;
            ap_r     <= 1'b0;
            bank_r   <= '0;
            cmd_r    <= CMD_NOP;
            cmd_bank <= '0;
            cmd_col  <= '0;
            cmd_ap   <= 1'b0;
        end else if (accept) begin
            state    <= ST_BURST;
            cnt      <= '0;
            x_r      <= x_eff;
            follow_r <= follow_e'(req_follow);
            ap_r     <= req_ap;
            bank_r   <= req_bank;
            cmd_r    <= CMD_READ;
            cmd_bank <= req_bank;
            cmd_col  <= req_col;
            cmd_ap   <= req_ap;
        end else if (last) begin
            state    <= ST_IDLE;
            cmd_r    <= end_cmd;
            cmd_bank <= bank_r;
        end else begin
            if (state == ST_BURST)
                cnt <= cnt + PAIR_W'(1);
            cmd_r <= CMD_NOP;
        end
    end

endmodule

// File: rtl/rdseq_window.sv
// Read data window and write-permit generator.
// Assumes: busy is high for exactly the cycles in which the device sends one pair
// per cycle (as seen at the command), so the window is busy delayed by CL_INT.
module rdseq_window #(
    parameter int CL_INT   = 2,
    parameter int TURN_GAP = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_cl_half,
    input  logic busy,
    output logic rd_win,
    output logic rd_win_fall,
    output logic wr_ok
);

    localparam int THR_MAX = CL_INT + TURN_GAP + 1;
    localparam int GAP_W   = $clog2(THR_MAX + 1) + 1;

    logic [CL_INT-1:0] stg;
    logic [GAP_W-1:0]  gap;
    logic [GAP_W-1:0]  thr;

    // Delay line, one stage per whole clock of read latency.
    generate
        for (genvar i = 0; i < CL_INT; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stg[i] <= 1'b0;
                else if (i == 0)
                    stg[i] <= busy;
                else
                    stg[i] <= stg[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign rd_win      = stg[CL_INT-1];
    assign rd_win_fall = rd_win && cfg_cl_half;

    // Cycles since the last pair was requested, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap <= '1;
        else if (busy)
            gap <= '0;
        else if (gap != '1)
            gap <= gap + GAP_W'(1);
    end

    assign thr   = GAP_W'(CL_INT + TURN_GAP) + GAP_W'(cfg_cl_half);
    assign wr_ok = !busy && (gap >= thr);

endmodule

// File: rtl/rdseq_bank_guard.sv
// Per-bank precharge-period timers; a bank is blocked while its timer runs.
// Assumes: pre_load pulses on the edge that puts PRECHARGE on the command output.
module rdseq_bank_guard #(
    parameter int NBANK  = 4,
    parameter int BANK_W = 2,
    parameter int TRP_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TRP_W-1:0]  cfg_trp,
    input  logic              pre_load,
    input  logic [BANK_W-1:0] pre_bank,
    output logic [NBANK-1:0]  blocked
);

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            logic [TRP_W-1:0] timer;

            // Load on precharge to this bank, otherwise count down to zero.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    timer <= '0;
                else if (pre_load && pre_bank == BANK_W'(b))
                    timer <= cfg_trp;
                else if (timer != '0)
                    timer <= timer - TRP_W'(1);
            end

            assign blocked[b] = (timer != '0);
        end
    endgenerate

endmodule

// File: rtl/ddr_rdseq.sv
// Top of the read-burst command sequencer: controller, data window, bank guard.
// Assumes: configuration inputs change only while no burst is in flight.
module ddr_rdseq #(
    parameter int NBANK    = 4,
    parameter int COL_W    = 10,
    parameter int PAIR_W   = 4,
    parameter int TRP_W    = 4,
    parameter int CL_INT   = 2,
    parameter int TURN_GAP = 1,
    localparam int BANK_W  = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_bl,
    input  logic              cfg_cl_half,
    input  logic [TRP_W-1:0]  cfg_trp,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [COL_W-1:0]  req_col,
    input  logic [PAIR_W-1:0] req_pairs,
    input  logic [1:0]        req_follow,
    input  logic              req_ap,
    output logic [1:0]        cmd_code,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [COL_W-1:0]  cmd_col,
    output logic              cmd_ap,
    output logic              rd_win,
    output logic              rd_win_fall,
    output logic              wr_ok
);

    logic              busy;
    logic              pre_load;
    logic [BANK_W-1:0] pre_bank;
    logic [NBANK-1:0]  blocked;
    logic              bank_blocked;

    assign bank_blocked = blocked[req_bank];

    rdseq_ctrl #(
        .BANK_W (BANK_W),
        .COL_W  (COL_W),
        .PAIR_W (PAIR_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_bl       (cfg_bl),
        .req_valid    (req_valid),
        .req_bank     (req_bank),
        .req_col      (req_col),
        .req_pairs    (req_pairs),
        .req_follow   (req_follow),
        .req_ap       (req_ap),
        .bank_blocked (bank_blocked),
        .req_ready    (req_ready),
        .cmd_code     (cmd_code),
        .cmd_bank     (cmd_bank),
        .cmd_col      (cmd_col),
        .cmd_ap       (cmd_ap),
        .busy         (busy),
        .pre_load     (pre_load),
        .pre_bank     (pre_bank)
    );

    rdseq_window #(
        .CL_INT   (CL_INT),
        .TURN_GAP (TURN_GAP)
    ) u_win (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_cl_half (cfg_cl_half),
        .busy        (busy),
        .rd_win      (rd_win),
        .rd_win_fall (rd_win_fall),
        .wr_ok       (wr_ok)
    );

    rdseq_bank_guard #(
        .NBANK  (NBANK),
        .BANK_W (BANK_W),
        .TRP_W  (TRP_W)
    ) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_trp  (cfg_trp),
        .pre_load (pre_load),
        .pre_bank (pre_bank),
        .blocked  (blocked)
    );

endmodule

// File: rtl/ddr_rdseq_chk.sv
// Port-level properties of the read-burst sequencer, bound to its top.
module ddr_rdseq_chk #(
    parameter int BANK_W = 2,
    parameter int TRP_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TRP_W-1:0]  cfg_trp,
    input logic              req_valid,
    input logic              req_ready,
    input logic [BANK_W-1:0] req_bank,
    input logic [1:0]        cmd_code,
    input logic [BANK_W-1:0] cmd_bank,
    input logic              rd_win,
    input logic              rd_win_fall,
    input logic              wr_ok
);

    // R2: an accepted request is followed by READ.
    a_r2_read_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (cmd_code == 2'd1));

    // R8: the data window opens two cycles after every READ.
    a_r8_window_lag: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == 2'd1) |-> ##2 rd_win);

    // R8: the falling-edge window never appears outside the window.
    a_r8_fall_inside: assert property (@(posedge clk) disable iff (!rst_n)
        rd_win_fall |-> rd_win);

    // R9: no write permit while read data is on the bus.
    a_r9_no_write_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        rd_win |-> !wr_ok);

    // R10: a just-precharged bank is refused.
    a_r10_pre_blocks_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == 2'd3 && req_bank == cmd_bank && cfg_trp != '0) |-> !req_ready);

endmodule

bind ddr_rdseq ddr_rdseq_chk #(
    .BANK_W (BANK_W),
    .TRP_W  (TRP_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_trp     (cfg_trp),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_bank    (req_bank),
    .cmd_code    (cmd_code),
    .cmd_bank    (cmd_bank),
    .rd_win      (rd_win),
    .rd_win_fall (rd_win_fall),
    .wr_ok       (wr_ok)
);

// File: tb/sim_ddr_rdseq.sv
// Directed bench for the read-burst sequencer: one task per scenario.
module sim_ddr_rdseq;

    localparam int NB = 4;
    localparam int BW = 2;
    localparam int CW = 10;
    localparam int PW = 4;
    localparam int TW = 4;

    localparam int C_NOP = 0, C_RD = 1, C_BST = 2, C_PRE = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_bl = 2'd1;
    logic          cfg_cl_half = 1'b0;
    logic [TW-1:0] cfg_trp = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [BW-1:0] req_bank = '0;
    logic [CW-1:0] req_col = '0;
    logic [PW-1:0] req_pairs = '0;
    logic [1:0]    req_follow = 2'd0;
    logic          req_ap = 1'b0;
    logic [1:0]    cmd_code;
    logic [BW-1:0] cmd_bank;
    logic [CW-1:0] cmd_col;
    logic          cmd_ap;
    logic          rd_win;
    logic          rd_win_fall;
    logic          wr_ok;

    int n_vec = 0;
    int n_bad = 0;
    int cmd_tr  [0:11];
    int win_tr  [0:11];
    int fall_tr [0:11];
    int wr_tr   [0:11];

    always #5 clk = ~clk;

    ddr_rdseq u0 (.*);

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // Drive one request at a negedge; returns at the negedge of READ cycle 0.
    task automatic issue(input int bank, input int col, input int pairs,
                         input int fol, input int ap);
        req_valid  = 1'b1;
        req_bank   = BW'(bank);
        req_col    = CW'(col);
        req_pairs  = PW'(pairs);
        req_follow = 2'(fol);
        req_ap     = ap[0];
        @(negedge clk);
        req_valid  = 1'b0;
    endtask

    // Record 12 cycles starting with the current one.
    task automatic trace;
        for (int k = 0; k < 12; k++) begin
            cmd_tr[k]  = int'(cmd_code);
            win_tr[k]  = int'(rd_win);
            fall_tr[k] = int'(rd_win_fall);
            wr_tr[k]   = int'(wr_ok);
            @(negedge clk);
        end
    endtask

    // Compare a trace with a burst of x pairs ending in end_cmd.
    task automatic expect_trace(input string rc, input int x, input int end_cmd,
                                input int half);
        for (int k = 0; k < 12; k++) begin
            int ec;
            ec = (k == 0) ? C_RD : ((k == x) ? end_cmd : C_NOP);
            chk(rc, $sformatf("cmd@%0d", k), cmd_tr[k], ec);
            chk("R8", $sformatf("win@%0d", k), win_tr[k], int'(k >= 2 && k <= x + 1));
            chk("R8", $sformatf("fall@%0d", k), fall_tr[k],
                int'(half == 1 && k >= 2 && k <= x + 1));
            chk("R9", $sformatf("wr_ok@%0d", k), wr_tr[k], int'(k >= x + 3 + half));
        end
    endtask

    // R1: reset values.
    task automatic t_reset;
        chk("R1", "cmd", int'(cmd_code), C_NOP);
        chk("R1", "rd_win", int'(rd_win), 0);
        chk("R1", "rd_win_fall", int'(rd_win_fall), 0);
        chk("R1", "wr_ok", int'(wr_ok), 1);
        chk("R1", "req_ready", int'(req_ready), 1);
    endtask

    // R2, R4: BL4, one pair wanted, then a write: terminate at cycle 1.
    task automatic t_truncate;
        cfg_bl = 2'd1; cfg_cl_half = 1'b0;
        issue(2, 5, 1, 2, 0);
        chk("R2", "cmd_bank", int'(cmd_bank), 2);
        chk("R2", "cmd_col", int'(cmd_col), 5);
        chk("R2", "cmd_ap", int'(cmd_ap), 0);
        trace();
        expect_trace("R4", 1, C_BST, 0);
    endtask

    // R3: clamping of oversize and zero pair counts, and BL2.
    task automatic t_clamp;
        cfg_bl = 2'd2;
        issue(0, 8, 9, 0, 0);
        trace();
        expect_trace("R3", 4, C_NOP, 0);
        issue(1, 3, 0, 0, 0);
        trace();
        expect_trace("R3", 4, C_NOP, 0);
        cfg_bl = 2'd0;
        issue(1, 4, 2, 0, 0);
        trace();
        expect_trace("R3", 1, C_NOP, 0);
    endtask

    // R5, R8, R9, R10: early precharge at CL 2.5 and the bank hold-off.
    task automatic t_precharge;
        cfg_bl = 2'd2; cfg_cl_half = 1'b1; cfg_trp = TW'(3);
        issue(3, 12, 2, 3, 0);
        trace();
        expect_trace("R5", 2, C_PRE, 1);
        // Second run to watch the guard cycle by cycle.
        issue(3, 12, 2, 3, 0);
        @(negedge clk);
        @(negedge clk);
        chk("R5", "pre_cmd", int'(cmd_code), C_PRE);
        chk("R5", "pre_bank", int'(cmd_bank), 3);
        for (int k = 2; k < 5; k++) begin
            req_bank = BW'(3);
            #1 chk("R10", $sformatf("same_bank_ready@%0d", k), int'(req_ready), 0);
            req_bank = BW'(1);
            #1 chk("R10", $sformatf("other_bank_ready@%0d", k), int'(req_ready), 1);
            @(negedge clk);
        end
        req_bank = BW'(3);
        #1 chk("R10", "same_bank_ready@5", int'(req_ready), 1);
        repeat (8) @(negedge clk);
        cfg_cl_half = 1'b0; cfg_trp = '0;
    endtask

    // R6: auto-precharge ignores the pair count and emits no end command.
    task automatic t_autopre;
        cfg_bl = 2'd1;
        issue(2, 6, 1, 3, 1);
        chk("R6", "cmd_ap", int'(cmd_ap), 1);
        trace();
        expect_trace("R6", 2, C_NOP, 0);
    endtask

    // R7: chained reads give a gap-free window; an unused chain point terminates.
    task automatic t_chain;
        cfg_bl = 2'd1;
        issue(0, 8, 2, 1, 0);
        chk("R7", "ready@0", int'(req_ready), 0);
        @(negedge clk);
        chk("R7", "ready@1", int'(req_ready), 1);
        issue(1, 16, 2, 0, 0);
        chk("R7", "second_read@2", int'(cmd_code), C_RD);
        chk("R7", "second_bank@2", int'(cmd_bank), 1);
        for (int k = 2; k < 7; k++) begin
            chk("R7", $sformatf("win@%0d", k), int'(rd_win), int'(k <= 5));
            chk("R7", $sformatf("cmd@%0d", k), int'(cmd_code), (k == 2) ? C_RD : C_NOP);
            @(negedge clk);
        end
        repeat (6) @(negedge clk);
        issue(0, 2, 1, 1, 0);
        trace();
        expect_trace("R7", 1, C_BST, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_truncate();
        t_clamp();
        t_precharge();
        t_autopre();
        t_chain();
        report();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

endmodule